// File: doc/BRIEF.md
# Transparent Four-Word Register File with Shared-Bus Read Port

This block is a tiny storage array: by default four words of four bits each, with a write side and a read side. Each side has its own address, so one word can be written while a different word is read. The write side uses level-sensitive latches. While its active-low strobe is held low, the addressed word follows the data input, and it keeps the last value when the strobe returns high.

The read side is purely combinational. The read address selects a word, and an active-low output enable places that word on a tri-state output. When the enable is high, the output floats, so several instances can share one bus. A read of the word being written shows the incoming data straight through the open latch. The interfaces are plain level signals, with no handshake and no back-pressure. The write address must be held steady for the whole time the write strobe is low.

Top module: `tlrf_top`

## Requirements
- R1: While `wr_en_n` is 0, the word at `wr_addr` takes the value of `wr_data`; once `wr_en_n` returns to 1, that word holds the value present just before the rise.
- R2: While `wr_en_n` stays 0, a later change of `wr_data` is copied into the addressed word, with no need for a new strobe.
- R3: While `wr_en_n` is 1, changes on `wr_data` and `wr_addr` leave every stored word unchanged.
- R4: While `rd_en_n` is 0, `rd_q` equals the word at `rd_addr`, bit for bit and not inverted.
- R5: While `rd_en_n` is 1, every bit of `rd_q` is high impedance, so another driver on the same bus sets the bus value alone.
- R6: Read selection does not depend on `wr_en_n`. While a write to one address is open, reading a different address returns that word's stored value.
- R7: While `wr_en_n` is 0 and `rd_addr` equals `wr_addr`, with `rd_en_n` at 0, `rd_q` follows `wr_data` combinationally.
- R8: A write changes only the addressed word; the other words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_addr | input | AW (2) | Word written while the strobe is low |
| wr_data | input | WIDTH (4) | Value loaded into the addressed word |
| wr_en_n | input | 1 | Active-low write strobe; latches are open while it is 0 |
| rd_addr | input | AW (2) | Word presented at the output |
| rd_en_n | input | 1 | Active-low output enable; 1 floats the output |
| rd_q | output | WIDTH (4) | Tri-state read data |

## Verification
Every address is written with all sixteen data values, and after each write all four words are read back. This separates a wrong decode, which corrupts a neighbour (R8), from a wrong store, which loses the written value (R1). Data changes while the strobe stays low tell true transparency apart from capture on an edge (R2). Address and data changes with the strobe high show whether anything leaks past a closed latch (R3). Reads of a different address during an open write, and of the same address, separate independent read selection (R6) from write-through (R7). A bench driver on the shared bus, driving the complement of the stored word while the output is disabled, shows whether the output really floats (R5).

// File: rtl/tlrf_pkg.sv
package tlrf_pkg;
  parameter int unsigned TLRF_WORDS = 4;
  parameter int unsigned TLRF_WIDTH = 4;
endpackage

// File: rtl/tlrf_wr_decode.sv
module tlrf_wr_decode #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned AW    = 2
) (
  input  logic [AW-1:0]    addr,
  input  logic             en_n,
  output logic [WORDS-1:0] strb
);
  always_comb begin
    strb = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (!en_n && (addr == AW'(i))) strb[i] = 1'b1;
    end
  end

  // R1: an open strobe selects exactly one word
  always_comb begin
    if (!en_n && (int'(addr) < WORDS))
      p_one_open_r1: assert ($countones(strb) == 1);
  end
endmodule

// File: rtl/tlrf_store.sv
module tlrf_store #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned WIDTH = 4
) (
  input  logic [WORDS-1:0]            strb,
  input  logic [WIDTH-1:0]            d,
  output logic [WORDS-1:0][WIDTH-1:0] words
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_latch begin
      if (strb[g]) words[g] = d;
    end

    // R2: an open latch tracks its data input
    always_comb begin
      if (strb[g]) p_track_r2: assert (words[g] == d);
    end
  end

  // R8: the decoder never opens two words at once
  always_comb begin
    p_single_wr_r8: assert ($onehot0(strb));
  end
endmodule

// File: rtl/tlrf_rd_sel.sv
module tlrf_rd_sel #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned WIDTH = 4,
  parameter int unsigned AW    = 2
) (
  input  logic [WORDS-1:0][WIDTH-1:0] words,
  input  logic [AW-1:0]               addr,
  output logic [WIDTH-1:0]            word
);
  always_comb begin
    word = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (addr == AW'(i)) word = words[i];
    end
  end
endmodule

// File: rtl/tlrf_out_drv.sv
module tlrf_out_drv #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] d,
  input  logic             en_n,
  output logic [WIDTH-1:0] q
);
  assign q = en_n ? {WIDTH{1'bz}} : d;
endmodule

// File: rtl/tlrf_top.sv
module tlrf_top #(
  parameter int unsigned WORDS = tlrf_pkg::TLRF_WORDS,
  parameter int unsigned WIDTH = tlrf_pkg::TLRF_WIDTH,
  parameter int unsigned AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_en_n,
  input  logic [AW-1:0]    rd_addr,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_q
);
  logic [WORDS-1:0]            strb;
  logic [WORDS-1:0][WIDTH-1:0] words;
  logic [WIDTH-1:0]            rd_word;

  tlrf_wr_decode #(.WORDS(WORDS), .AW(AW)) u_dec (
    .addr(wr_addr), .en_n(wr_en_n), .strb(strb)
  );

  tlrf_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
    .strb(strb), .d(wr_data), .words(words)
  );

  tlrf_rd_sel #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_sel (
    .words(words), .addr(rd_addr), .word(rd_word)
  );

  tlrf_out_drv #(.WIDTH(WIDTH)) u_drv (
    .d(rd_word), .en_n(rd_en_n), .q(rd_q)
  );

  // R7: a read of the word being written shows the incoming data
  always_comb begin
    if (!wr_en_n && (rd_addr == wr_addr) && (int'(wr_addr) < WORDS))
      p_wr_through_r7: assert (rd_word == wr_data);
  end
endmodule

// File: tb/tlrf_top_tb.sv
module tlrf_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 4;
  localparam int WIDTH = 4;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic wr_en_n = 1'b1, rd_en_n = 1'b1;
  logic tb_drv_en = 1'b0;
  logic [WIDTH-1:0] tb_val = '0;
  wire  [WIDTH-1:0] bus;

  logic [WIDTH-1:0] model [WORDS];
  int n_checks = 0, n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlrf_top #(.WORDS(WORDS), .WIDTH(WIDTH)) u_dut (
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en_n(wr_en_n),
    .rd_addr(rd_addr), .rd_en_n(rd_en_n), .rd_q(bus)
  );

  assign bus = tb_drv_en ? tb_val : {WIDTH{1'bz}};

  task automatic check(input string req, input logic [WIDTH-1:0] got,
                       input logic [WIDTH-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    #(CLK_PERIOD/2);
  endtask

  task automatic do_write(input int a, input logic [WIDTH-1:0] d);
    wr_addr = AW'(a); wr_data = d; step();
    wr_en_n = 1'b0; step();
    wr_en_n = 1'b1; step();
    model[a] = d;
  endtask

  task automatic read_all(input string req);
    rd_en_n = 1'b0;
    for (int a = 0; a < WORDS; a++) begin
      rd_addr = AW'(a); step();
      check(req, bus, model[a]);
    end
  endtask

  initial begin
    // initialise every word (R1)
    for (int a = 0; a < WORDS; a++) do_write(a, WIDTH'(a * 5 + 1));
    read_all("R1 init");

    // exhaustive sweep: address x data, then read all (R1, R4, R8)
    for (int a = 0; a < WORDS; a++) begin
      for (int v = 0; v < (1 << WIDTH); v++) begin
        do_write(a, WIDTH'(v ^ (a * 3)));
        read_all("R1/R4/R8 sweep");
      end
    end

    // R2 transparency and R7 write-through on the same address
    wr_addr = 2'd2; wr_data = 4'h5; rd_addr = 2'd2; rd_en_n = 1'b0; step();
    wr_en_n = 1'b0; step();
    check("R7 write-through", bus, 4'h5);
    wr_data = 4'hA; step();
    check("R7 follows data", bus, 4'hA);
    wr_data = 4'h9; step();
    check("R2 tracking", bus, 4'h9);
    // R6: reading another word while the write is still open
    rd_addr = 2'd0; step();
    check("R6 independent read", bus, model[0]);
    rd_addr = 2'd3; step();
    check("R6 independent read", bus, model[3]);
    wr_en_n = 1'b1; step();
    model[2] = 4'h9;
    // R3: inputs move while the strobe is high
    wr_data = 4'h0; step();
    wr_addr = 2'd1; wr_data = 4'hF; step();
    wr_addr = 2'd3; wr_data = 4'h6; step();
    read_all("R3 hold");
    rd_addr = 2'd2; step();
    check("R3 value before rise kept", bus, 4'h9);

    // R5: output floats, bench drives the complement on the shared bus
    for (int a = 0; a < WORDS; a++) begin
      rd_addr = AW'(a); rd_en_n = 1'b1; step();
      tb_val = ~model[a]; tb_drv_en = 1'b1; step();
      check("R5 bus released", bus, ~model[a]);
      tb_drv_en = 1'b0; step();
      rd_en_n = 1'b0; step();
      check("R4 output reenabled", bus, model[a]);
    end

    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (done || cycles > 100000) begin
      if (!done) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule